// File: doc/BRIEF.md
# External Bus Read Cycle Sequencer

The sequencer turns a single-cycle internal read request into a read cycle on an external 8-bit style bus. Each of the chip-select regions has its own setting. In pass-through mode the bus strobes follow the internal request directly: there is one bus clock, and the data is taken at its end. In legacy mode the read runs through three bus states, T1, T2 and T3. Wait states can be inserted after T2, and the number of system clocks spent in each bus state is programmable for each region.

The requester supplies the region index, the address and a memory/I/O flag. The requester must hold the request until the sequencer is idle. While busy, the sequencer ignores new requests. It returns a one-cycle done pulse along with the captured data byte. The configuration is written one region at a time through a small write port.

Top module: `ext_bus_seq`

## Requirements
- R1: After reset every region is in pass-through mode with a clocks-per-state value of 0. busy_o and done_o are low, every chip select is high (inactive), and the read, memory-request and I/O-request strobes are high.
- R2: A request is accepted only on a clock edge where req_i is high and busy_o is low. Requests raised while busy_o is high do not change the cycle in progress or the driven address.
- R3: In legacy mode the first bus state is T1. In T1 the latched address is driven and only the selected chip select (bit index = region) is low. All strobes stay high.
- R4: In T2, TW and T3, bus_rd_no is low. In the same cycles bus_mreq_no is low when req_io_i was 0 at acceptance, and bus_iorq_no is low when req_io_i was 1. Never both.
- R5: T1, T2 and T3 each last exactly max(cfg value, 1) system clocks, using the value of the selected region. A value of 0 gives 1 clock.
- R6: bus_wait_ni is sampled only at the clock edge that ends the last clock of T2, and in TW. If it is low at that edge, wait states follow, one per clock, until an edge at which it is high. T3 then begins. A low level during T1 or T3 has no effect.
- R7: No bus output changes during T3. Read data is captured at the clock edge that ends T3.
- R8: In the clock after the capture edge, done_o is high for exactly one cycle and rdata_o holds the captured byte. All strobes and chip selects are high in that same cycle.
- R9: In pass-through mode, the cycle after acceptance drives the chip select, bus_rd_no and the memory-request or I/O-request strobe low together for one clock. bus_wait_ni is ignored, and data is captured at the end of that clock.
- R10: The mode (1 = legacy) and the clocks-per-state value are written per region through cfg_we_i/cfg_sel_i. Each region keeps its own setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | 2 | Region written |
| cfg_legacy_i | input | 1 | Mode to write: 1 legacy, 0 pass-through |
| cfg_tclk_i | input | 4 | Clocks-per-state value to write |
| req_i | input | 1 | Read request |
| req_io_i | input | 1 | 1 = I/O access, 0 = memory access |
| req_cs_i | input | 2 | Region of the request |
| req_addr_i | input | 16 | Read address |
| busy_o | output | 1 | Sequencer not idle |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Captured read data |
| bus_addr_o | output | 16 | External address bus |
| bus_cs_no | output | 4 | Chip selects, active low |
| bus_rd_no | output | 1 | Read strobe, active low |
| bus_mreq_no | output | 1 | Memory-request strobe, active low |
| bus_iorq_no | output | 1 | I/O-request strobe, active low |
| bus_wait_ni | input | 1 | Wait request, active low |
| bus_data_i | input | 8 | External data bus |

## Verification
The assertions assume that the requester holds req_i only as a request and accepts that it may be ignored while busy_o is high. They also assume that the configuration of a region does not change while a read to that region is in flight. The stimulus writes configuration only between reads, while the sequencer is idle. It raises extra requests during a read only to show that they are dropped. It drives bus_wait_ni low in T1 and in pass-through cycles to show that the level is ignored there. A legal bus is assumed to release WAIT eventually, and every stimulus pattern releases it after a bounded number of wait states.

// File: rtl/ext_bus_pkg.sv
package ext_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PASS,
    ST_T1,
    ST_T2,
    ST_TW,
    ST_T3,
    ST_DONE
  } bus_state_e;
endpackage

// File: rtl/ebs_cfg_regs.sv
module ebs_cfg_regs #(
  parameter int N_CS   = 4,
  parameter int TCLK_W = 4,
  parameter int CS_W   = 2
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic [CS_W-1:0]          sel_i,
  input  logic                     legacy_i,
  input  logic [TCLK_W-1:0]        tclk_i,
  output logic [N_CS-1:0]          legacy_o,
  output logic [N_CS*TCLK_W-1:0]   tclk_o
);
  for (genvar g = 0; g < N_CS; g++) begin : g_region
    logic              mode_q;
    logic [TCLK_W-1:0] tclk_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q <= 1'b0;
        tclk_q <= '0;
      end else if (we_i && sel_i == CS_W'(g)) begin
        mode_q <= legacy_i;
        tclk_q <= tclk_i;
      end
    end
    assign legacy_o[g] = mode_q;
    assign tclk_o[g*TCLK_W +: TCLK_W] = tclk_q;
  end
endmodule

// File: rtl/ebs_state_timer.sv
module ebs_state_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= load_val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end
  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/ebs_read_fsm.sv
module ebs_read_fsm
  import ext_bus_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       legacy_i,
  input  logic       last_i,
  input  logic       wait_ni,
  output bus_state_e state_o,
  output logic       load_o,
  output logic       capture_o
);
  bus_state_e state_q, state_d;

  always_comb begin
    state_d   = state_q;
    load_o    = 1'b0;
    capture_o = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        state_d = legacy_i ? ST_T1 : ST_PASS;
        load_o  = legacy_i;
      end
      ST_PASS: begin
        state_d   = ST_DONE;
        capture_o = 1'b1;
      end
      ST_T1: if (last_i) begin
        state_d = ST_T2;
        load_o  = 1'b1;
      end
      ST_T2: if (last_i) begin
        state_d = wait_ni ? ST_T3 : ST_TW;
        load_o  = wait_ni;
      end
      ST_TW: if (wait_ni) begin
        state_d = ST_T3;
        load_o  = 1'b1;
      end
      ST_T3: if (last_i) begin
        state_d   = ST_DONE;
        capture_o = 1'b1;
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/ext_bus_seq.sv
module ext_bus_seq
  import ext_bus_pkg::*;
#(
  parameter int N_CS   = 4,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int TCLK_W = 4,
  localparam int CS_W  = (N_CS > 1) ? $clog2(N_CS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [CS_W-1:0]   cfg_sel_i,
  input  logic              cfg_legacy_i,
  input  logic [TCLK_W-1:0] cfg_tclk_i,
  input  logic              req_i,
  input  logic              req_io_i,
  input  logic [CS_W-1:0]   req_cs_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic [N_CS-1:0]   bus_cs_no,
  output logic              bus_rd_no,
  output logic              bus_mreq_no,
  output logic              bus_iorq_no,
  input  logic              bus_wait_ni,
  input  logic [DATA_W-1:0] bus_data_i
);
  logic [N_CS-1:0]        legacy_all;
  logic [N_CS*TCLK_W-1:0] tclk_all;
  logic [TCLK_W-1:0]      tclk_arr [N_CS];

  ebs_cfg_regs #(.N_CS(N_CS), .TCLK_W(TCLK_W), .CS_W(CS_W)) u_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .sel_i    (cfg_sel_i),
    .legacy_i (cfg_legacy_i),
    .tclk_i   (cfg_tclk_i),
    .legacy_o (legacy_all),
    .tclk_o   (tclk_all)
  );

  for (genvar g = 0; g < N_CS; g++) begin : g_tclk
    assign tclk_arr[g] = tclk_all[g*TCLK_W +: TCLK_W];
  end

  bus_state_e state;
  logic       load, last, capture, accept;
  logic [TCLK_W-1:0] sel_tclk, new_nm1, nm1_q, load_val;

  assign accept   = req_i && (state == ST_IDLE);
  assign sel_tclk = tclk_arr[req_cs_i];
  // zero setting behaves as one clock per state
  assign new_nm1  = (sel_tclk == '0) ? '0 : sel_tclk - TCLK_W'(1);
  assign load_val = (state == ST_IDLE) ? new_nm1 : nm1_q;

  ebs_state_timer #(.W(TCLK_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .last_o     (last)
  );

  ebs_read_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_i),
    .legacy_i  (legacy_all[req_cs_i]),
    .last_i    (last),
    .wait_ni   (bus_wait_ni),
    .state_o   (state),
    .load_o    (load),
    .capture_o (capture)
  );

  logic [ADDR_W-1:0] addr_q;
  logic [CS_W-1:0]   cs_q;
  logic              io_q;
  logic [DATA_W-1:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cs_q   <= '0;
      io_q   <= 1'b0;
      nm1_q  <= '0;
    end else if (accept) begin
      addr_q <= req_addr_i;
      cs_q   <= req_cs_i;
      io_q   <= req_io_i;
      nm1_q  <= new_nm1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (capture) rdata_q <= bus_data_i;
  end

  logic cs_act, strb_act;
  assign cs_act   = state inside {ST_PASS, ST_T1, ST_T2, ST_TW, ST_T3};
  assign strb_act = state inside {ST_PASS, ST_T2, ST_TW, ST_T3};

  for (genvar g = 0; g < N_CS; g++) begin : g_cs
    assign bus_cs_no[g] = !(cs_act && cs_q == CS_W'(g));
  end

  assign bus_addr_o  = addr_q;
  assign bus_rd_no   = !strb_act;
  assign bus_mreq_no = !(strb_act && !io_q);
  assign bus_iorq_no = !(strb_act && io_q);
  assign busy_o      = (state != ST_IDLE);
  assign done_o      = (state == ST_DONE);
  assign rdata_o     = rdata_q;
endmodule

// File: rtl/ext_bus_seq_chk.sv
module ext_bus_seq_chk #(
  parameter int N_CS   = 4,
  parameter int ADDR_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              busy_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] bus_addr_o,
  input logic [N_CS-1:0]   bus_cs_no,
  input logic              bus_rd_no,
  input logic              bus_mreq_no,
  input logic              bus_iorq_no
);
  // R3
  one_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~bus_cs_no));
  // R4
  one_req_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_no |-> (bus_mreq_no ^ bus_iorq_no));
  // R4
  strobe_needs_rd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_mreq_no || !bus_iorq_no) |-> !bus_rd_no);
  // R3
  rd_needs_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_rd_no |-> !(&bus_cs_no));
  // R8
  done_idle_bus_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (bus_rd_no && bus_mreq_no && bus_iorq_no && (&bus_cs_no)));
  // R8
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R2
  busy_addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(bus_addr_o));
  // R2
  accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !busy_o) |=> busy_o);
endmodule

bind ext_bus_seq ext_bus_seq_chk #(.N_CS(N_CS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_i       (req_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .bus_addr_o  (bus_addr_o),
  .bus_cs_no   (bus_cs_no),
  .bus_rd_no   (bus_rd_no),
  .bus_mreq_no (bus_mreq_no),
  .bus_iorq_no (bus_iorq_no)
);

// File: tb/ext_bus_seq_test.sv
`timescale 1ns/1ps
module ext_bus_seq_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0, cfg_legacy_i = 1'b0;
  logic [1:0]  cfg_sel_i = '0;
  logic [3:0]  cfg_tclk_i = '0;
  logic        req_i = 1'b0, req_io_i = 1'b0;
  logic [1:0]  req_cs_i = '0;
  logic [15:0] req_addr_i = '0;
  logic        busy_o, done_o;
  logic [7:0]  rdata_o;
  logic [15:0] bus_addr_o;
  logic [3:0]  bus_cs_no;
  logic        bus_rd_no, bus_mreq_no, bus_iorq_no;
  logic        bus_wait_ni = 1'b1;
  logic [7:0]  bus_data_i = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ext_bus_seq uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i), .cfg_legacy_i(cfg_legacy_i), .cfg_tclk_i(cfg_tclk_i),
    .req_i(req_i), .req_io_i(req_io_i), .req_cs_i(req_cs_i), .req_addr_i(req_addr_i),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o),
    .bus_addr_o(bus_addr_o), .bus_cs_no(bus_cs_no), .bus_rd_no(bus_rd_no),
    .bus_mreq_no(bus_mreq_no), .bus_iorq_no(bus_iorq_no),
    .bus_wait_ni(bus_wait_ni), .bus_data_i(bus_data_i)
  );

  task automatic check(input string tag, input logic [24:0] got, input logic [24:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [24:0] snap();
    return {bus_cs_no, bus_rd_no, bus_mreq_no, bus_iorq_no, busy_o, done_o, bus_addr_o};
  endfunction

  task automatic cfg_write(input int sel, input bit legacy, input int tclk);
    @(negedge clk);
    cfg_we_i = 1'b1; cfg_sel_i = 2'(sel); cfg_legacy_i = legacy; cfg_tclk_i = 4'(tclk);
    @(negedge clk);
    cfg_we_i = 1'b0;
  endtask

  // phases: 1 T1, 2 T2, 3 TW, 4 T3, 5 pass, 6 done
  task automatic do_read(input int cs, input bit io, input logic [15:0] addr,
                         input logic [7:0] dat, input bit legacy, input int n,
                         input int w, input bit wait_t1, input bit poke, input string tag);
    int ph[$]; bit wv[$]; logic [7:0] dv[$];
    if (legacy) begin
      for (int i = 0; i < n; i++) begin ph.push_back(1); wv.push_back(!wait_t1); dv.push_back(~dat); end
      for (int i = 0; i < n; i++) begin
        ph.push_back(2); wv.push_back((i == n-1) ? (w == 0) : 1'b1); dv.push_back(~dat);
      end
      for (int j = 0; j < w; j++) begin ph.push_back(3); wv.push_back(j == w-1); dv.push_back(~dat); end
      for (int i = 0; i < n; i++) begin
        ph.push_back(4); wv.push_back(1'b1); dv.push_back((i == n-1) ? dat : ~dat);
      end
    end else begin
      ph.push_back(5); wv.push_back(1'b0); dv.push_back(dat);
    end
    ph.push_back(6); wv.push_back(1'b1); dv.push_back(~dat);

    @(negedge clk);
    req_i = 1'b1; req_io_i = io; req_cs_i = 2'(cs); req_addr_i = addr;
    @(negedge clk);
    req_i = 1'b0;
    for (int i = 0; i < ph.size(); i++) begin
      bit cs_act, strb;
      logic [24:0] exp;
      cs_act = (ph[i] <= 5);
      strb   = (ph[i] >= 2 && ph[i] <= 5);
      exp = {cs_act ? ~(4'b1 << cs) : 4'hF, !strb, !(strb && !io), !(strb && io),
             1'b1, ph[i] == 6, addr};
      check($sformatf("%s cycle %0d", tag, i), snap(), exp);
      if (ph[i] == 6) check($sformatf("%s rdata R8", tag), {17'd0, rdata_o}, {17'd0, dat});
      // R2: extra requests while busy must be dropped
      if (poke && i >= 1 && i <= 2) begin req_i = 1'b1; req_addr_i = ~addr; req_cs_i = 2'(cs + 1); end
      else req_i = 1'b0;
      bus_wait_ni = wv[i];
      bus_data_i  = dv[i];
      @(negedge clk);
    end
    req_i = 1'b0; bus_wait_ni = 1'b1;
    check({tag, " back to idle R2"}, snap(), {4'hF, 3'b111, 2'b00, addr});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset outputs", snap(), {4'hF, 3'b111, 2'b00, 16'h0000});
    // R1 R9: default pass-through, memory
    do_read(0, 1'b0, 16'h1234, 8'hA5, 1'b0, 1, 0, 1'b0, 1'b0, "R1/R9 pass mem");
    // R9 pass-through I/O on another region
    do_read(2, 1'b1, 16'h00F0, 8'h3C, 1'b0, 1, 0, 1'b0, 1'b0, "R9 pass io");
    // R5: value 0 gives one clock per state
    cfg_write(1, 1'b1, 0);
    do_read(1, 1'b0, 16'hBEEF, 8'h5A, 1'b1, 1, 0, 1'b0, 1'b0, "R3/R4/R5/R7 n1");
    // R6 wait states with three clocks per state, plus busy requests
    cfg_write(2, 1'b1, 3);
    do_read(2, 1'b1, 16'h8001, 8'hC3, 1'b1, 3, 2, 1'b0, 1'b1, "R2/R4/R6 n3 w2");
    // R6: low WAIT during T1 ignored
    cfg_write(3, 1'b1, 2);
    do_read(3, 1'b0, 16'h4422, 8'h99, 1'b1, 2, 0, 1'b1, 1'b0, "R6 t1 wait ignored");
    // R10: region 0 remains pass-through while others are legacy
    do_read(0, 1'b1, 16'h7777, 8'h01, 1'b0, 1, 0, 1'b0, 1'b1, "R10 region0 pass");
    // R6 single wait state at one clock per state
    do_read(1, 1'b1, 16'h0102, 8'hFE, 1'b1, 1, 1, 1'b0, 1'b0, "R6 n1 w1");
    // R10: region 2 rewritten back to pass-through, region 3 untouched
    cfg_write(2, 1'b0, 5);
    do_read(2, 1'b0, 16'hAAAA, 8'h55, 1'b0, 1, 0, 1'b0, 1'b0, "R10 region2 pass");
    do_read(3, 1'b1, 16'h0BAD, 8'h42, 1'b1, 2, 3, 1'b0, 1'b0, "R5/R10 region3 n2 w3");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule